// File: doc/BRIEF.md
# Branch Hazard Control Unit

This unit decides what the fetch stage does around branches and jumps in a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Branches and jumps are resolved in execute, so the correct next address is known only two cycles after the branch was fetched. The surrounding pipeline reports whether the word in decode and the word in execute are control-transfer instructions. Execute also reports the resolved direction and target. The unit returns the next-PC selection, the PC write enable, and the write enable and flush for the fetch/decode register. It also returns a flush for the decode/execute register. A flush loads an all-zero nop with its valid bit cleared, so the word writes no register and no memory.

The handling policy is chosen at compile time through the `POLICY` parameter:
- **Stall and zap** holds the PC for one cycle while a branch sits in decode and zaps the fetched word.
- **Delay slot** always runs the one word after a branch, and on a taken branch squashes only the word fetched after that slot.
- **Speculative** assumes not-taken. On a taken outcome it squashes both younger words, a two-instruction penalty.

The unit keeps its own record of which pipeline slots hold live words. A branch that has been zapped therefore never redirects the PC.

Top module: `br_hazard_ctl`

## Requirements
- R1: While `rst_n` is low the unit drives `pc_sel`=3 (zero) with `pc_next`=0 and `pc_we`=1, drives `ifid_flush`=1 and `idex_flush`=1, and drives `ifid_we`=0. In the first cycle after release, no branch is pending, so `id_cti`/`ex_cti` have no effect.
- R2: With no live branch anywhere, the unit selects sequential fetch: `pc_sel`=0, `pc_next`=`pc_plus4`, `pc_we`=1, `ifid_we`=1, and both flushes are 0.
- R3: In every policy, a live branch in execute with `ex_taken`=1 gives `pc_sel`=1, `pc_next`=`ex_target`, `pc_we`=1, `ifid_flush`=1 and `ifid_we`=0.
- R4: A live branch in execute with `ex_taken`=0 leaves the fetch path sequential, exactly as in R2.
- R5: In the stall policy, a live branch in decode with no redirect in the same cycle gives `pc_sel`=2 (hold), `pc_we`=0, `ifid_flush`=1, `ifid_we`=0 and `idex_flush`=0. The hold lasts exactly one cycle.
- R6: In the delay-slot policy, a branch in decode has no effect, `pc_we` is never low, and `idex_flush` is never asserted, so the slot word always survives.
- R7: In the speculative policy, a branch in decode has no effect. A taken redirect also asserts `idex_flush`, squashing two words.
- R8: A word in decode is live only if `ifid_flush` was low in the cycle it was loaded. A word in execute is live only if it was live in decode and `idex_flush` was low as it moved on. `id_cti`/`ex_cti` of a dead word are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_cti | input | 1 | Word in decode is a branch or jump |
| ex_cti | input | 1 | Word in execute is a branch or jump |
| ex_taken | input | 1 | Resolved outcome of the branch in execute |
| ex_target | input | AW | Resolved target address from execute |
| pc_plus4 | input | AW | Sequential next fetch address |
| pc_next | output | AW | Address to load into the PC |
| pc_sel | output | 2 | 0 sequential, 1 target, 2 hold, 3 zero |
| pc_we | output | 1 | PC write enable |
| ifid_we | output | 1 | Fetch/decode register loads the fetched word |
| ifid_flush | output | 1 | Fetch/decode register loads a nop instead |
| idex_flush | output | 1 | Decode/execute register loads a nop instead |

## Verification
All three policies run side by side on one input sequence:
- A plain stream shows the sequential path.
- A not-taken resolve and a taken resolve separate the R4 path from the redirect.
- A branch in decode followed by a taken branch in execute separates the policies: stall holds, the delay slot keeps its slot, and speculation squashes two words.
- Branches that follow a zap, or come straight after reset, check that dead words never redirect.
- A reset in the middle of a branch shows that no pending state survives.

// File: rtl/bhc_pkg.sv
package bhc_pkg;

    typedef enum logic [1:0] {
        POL_STALL = 2'd0,
        POL_DSLOT = 2'd1,
        POL_SPEC  = 2'd2
    } policy_e;

    typedef enum logic [1:0] {
        PCS_SEQ  = 2'd0,
        PCS_TGT  = 2'd1,
        PCS_HOLD = 2'd2,
        PCS_ZERO = 2'd3
    } pcsel_e;

    typedef struct packed {
        logic id_live;
        logic ex_live;
    } live_s;

    typedef struct packed {
        logic redirect;
        logic hold;
        logic ifid_flush;
        logic idex_flush;
    } act_s;

    typedef struct packed {
        pcsel_e sel;
        logic   pc_we;
        logic   ifid_we;
        logic   ifid_flush;
        logic   idex_flush;
    } ctl_s;

endpackage

// File: rtl/bhc_live_track.sv
module bhc_live_track (
    input  logic clk,
    input  logic rst_n,
    input  logic ifid_flush,
    input  logic idex_flush,
    output logic id_live,
    output logic ex_live
);
    import bhc_pkg::*;

    live_s live_d, live_q;

    always_comb begin
        live_d         = live_q;
        live_d.id_live = ~ifid_flush;
        live_d.ex_live = live_q.id_live & ~idex_flush;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= '0;
        else        live_q <= live_d;
    end

    assign id_live = live_q.id_live;
    assign ex_live = live_q.ex_live;

    AST_ZAPPED_FETCH_DEAD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ifid_flush) |-> !id_live);                          // R8
    AST_DEAD_DECODE_STAYS_DEAD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!id_live) |-> !ex_live);                            // R8

endmodule

// File: rtl/bhc_policy.sv
module bhc_policy #(
    parameter bhc_pkg::policy_e POLICY = bhc_pkg::POL_SPEC
) (
    input  logic           id_br,
    input  logic           ex_br,
    input  logic           ex_taken,
    output bhc_pkg::act_s  act
);
    import bhc_pkg::*;

    logic redirect;
    assign redirect = ex_br & ex_taken;

    generate
        if (POLICY == POL_STALL) begin : g_stall
            always_comb begin
                act            = '0;
                act.redirect   = redirect;
                act.hold       = id_br & ~redirect;
                act.ifid_flush = redirect | id_br;
                act.idex_flush = 1'b0;
            end
        end else if (POLICY == POL_DSLOT) begin : g_dslot
            always_comb begin
                act            = '0;
                act.redirect   = redirect;
                act.hold       = 1'b0;
                act.ifid_flush = redirect;
                act.idex_flush = 1'b0;
            end
        end else begin : g_spec
            always_comb begin
                act            = '0;
                act.redirect   = redirect;
                act.hold       = 1'b0;
                act.ifid_flush = redirect;
                act.idex_flush = redirect;
            end
        end
    endgenerate

endmodule

// File: rtl/bhc_pc_mux.sv
module bhc_pc_mux #(
    parameter int AW = 32
) (
    input  bhc_pkg::pcsel_e sel,
    input  logic [AW-1:0]   pc_plus4,
    input  logic [AW-1:0]   ex_target,
    output logic [AW-1:0]   pc_next
);
    import bhc_pkg::*;

    always_comb begin
        unique case (sel)
            PCS_TGT:  pc_next = ex_target;
            PCS_ZERO: pc_next = '0;
            default:  pc_next = pc_plus4;
        endcase
    end

endmodule

// File: rtl/br_hazard_ctl.sv
module br_hazard_ctl #(
    parameter int               AW     = 32,
    parameter bhc_pkg::policy_e POLICY = bhc_pkg::POL_SPEC
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          id_cti,
    input  logic          ex_cti,
    input  logic          ex_taken,
    input  logic [AW-1:0] ex_target,
    input  logic [AW-1:0] pc_plus4,
    output logic [AW-1:0] pc_next,
    output logic [1:0]    pc_sel,
    output logic          pc_we,
    output logic          ifid_we,
    output logic          ifid_flush,
    output logic          idex_flush
);
    import bhc_pkg::*;

    logic id_live, ex_live;
    logic id_br, ex_br;
    act_s act;
    ctl_s ctl;

    assign id_br = id_cti & id_live;
    assign ex_br = ex_cti & ex_live;

    bhc_live_track u_live (
        .clk        (clk),
        .rst_n      (rst_n),
        .ifid_flush (ctl.ifid_flush),
        .idex_flush (ctl.idex_flush),
        .id_live    (id_live),
        .ex_live    (ex_live)
    );

    bhc_policy #(.POLICY(POLICY)) u_policy (
        .id_br    (id_br),
        .ex_br    (ex_br),
        .ex_taken (ex_taken),
        .act      (act)
    );

    always_comb begin
        ctl = '{sel: PCS_SEQ, pc_we: 1'b1, ifid_we: 1'b1,
                ifid_flush: 1'b0, idex_flush: 1'b0};
        if (!rst_n) begin
            ctl.sel        = PCS_ZERO;
            ctl.ifid_flush = 1'b1;
            ctl.idex_flush = 1'b1;
        end else if (act.redirect) begin
            ctl.sel        = PCS_TGT;
            ctl.ifid_flush = act.ifid_flush;
            ctl.idex_flush = act.idex_flush;
        end else if (act.hold) begin
            ctl.sel        = PCS_HOLD;
            ctl.pc_we      = 1'b0;
            ctl.ifid_flush = act.ifid_flush;
        end
        ctl.ifid_we = ~ctl.ifid_flush;
    end

    bhc_pc_mux #(.AW(AW)) u_mux (
        .sel       (ctl.sel),
        .pc_plus4  (pc_plus4),
        .ex_target (ex_target),
        .pc_next   (pc_next)
    );

    assign pc_sel     = ctl.sel;
    assign pc_we      = ctl.pc_we;
    assign ifid_we    = ctl.ifid_we;
    assign ifid_flush = ctl.ifid_flush;
    assign idex_flush = ctl.idex_flush;

    AST_REDIRECT_ZAPS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_sel == 2'd1) |-> (ifid_flush && pc_next == ex_target));  // R3
    AST_SQUASHED_NEVER_REDIRECTS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(idex_flush) |-> (pc_sel != 2'd1));                     // R8

    generate
        if (POLICY == POL_STALL) begin : g_chk_stall
            AST_HOLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
                $past(!pc_we) |-> pc_we);                                // R5
        end else if (POLICY == POL_DSLOT) begin : g_chk_dslot
            AST_SLOT_SURVIVES: assert property (@(posedge clk) disable iff (!rst_n)
                !idex_flush && pc_we);                                   // R6
        end else begin : g_chk_spec
            AST_DOUBLE_SQUASH: assert property (@(posedge clk) disable iff (!rst_n)
                (pc_sel == 2'd1) |-> idex_flush);                        // R7
            AST_SPEC_NEVER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
                pc_we);                                                  // R7
        end
    endgenerate

endmodule

// File: tb/br_hazard_ctl_tb_top.sv
module br_hazard_ctl_tb_top;
    import bhc_pkg::*;

    localparam int AW = 32;
    localparam int NV = 15;

    // {rst_n, id_cti, ex_cti, ex_taken, stall{sel,fi,fe}, dslot{sel,fi,fe}, spec{sel,fi,fe}}
    localparam logic [15:0] VEC [NV] = '{
        16'b0_000_1111_1111_1111,
        16'b1_111_0000_0000_0000,
        16'b1_000_0000_0000_0000,
        16'b1_010_0000_0000_0000,
        16'b1_100_1010_0000_0000,
        16'b1_011_0110_0110_0111,
        16'b1_011_0000_0110_0000,
        16'b1_111_1010_0000_0000,
        16'b1_010_0000_0000_0000,
        16'b1_111_1010_0110_0111,
        16'b0_000_1111_1111_1111,
        16'b1_011_0000_0000_0000,
        16'b1_000_0000_0000_0000,
        16'b1_110_1010_0000_0000,
        16'b1_011_0110_0110_0111
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          id_cti = 1'b0, ex_cti = 1'b0, ex_taken = 1'b0;
    logic [AW-1:0] ex_target = '0, pc_plus4 = '0;

    logic [AW-1:0] pcn_o [3];
    logic [1:0]    sel_o [3];
    logic          pwe_o [3], iwe_o [3], fi_o [3], fe_o [3];

    int  n_chk = 0, n_fail = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    br_hazard_ctl #(.AW(AW), .POLICY(POL_STALL)) dut_stall_i (
        .clk(clk), .rst_n(rst_n), .id_cti(id_cti), .ex_cti(ex_cti), .ex_taken(ex_taken),
        .ex_target(ex_target), .pc_plus4(pc_plus4), .pc_next(pcn_o[0]), .pc_sel(sel_o[0]),
        .pc_we(pwe_o[0]), .ifid_we(iwe_o[0]), .ifid_flush(fi_o[0]), .idex_flush(fe_o[0]));

    br_hazard_ctl #(.AW(AW), .POLICY(POL_DSLOT)) dut_slot_i (
        .clk(clk), .rst_n(rst_n), .id_cti(id_cti), .ex_cti(ex_cti), .ex_taken(ex_taken),
        .ex_target(ex_target), .pc_plus4(pc_plus4), .pc_next(pcn_o[1]), .pc_sel(sel_o[1]),
        .pc_we(pwe_o[1]), .ifid_we(iwe_o[1]), .ifid_flush(fi_o[1]), .idex_flush(fe_o[1]));

    br_hazard_ctl #(.AW(AW), .POLICY(POL_SPEC)) dut_i (
        .clk(clk), .rst_n(rst_n), .id_cti(id_cti), .ex_cti(ex_cti), .ex_taken(ex_taken),
        .ex_target(ex_target), .pc_plus4(pc_plus4), .pc_next(pcn_o[2]), .pc_sel(sel_o[2]),
        .pc_we(pwe_o[2]), .ifid_we(iwe_o[2]), .ifid_flush(fi_o[2]), .idex_flush(fe_o[2]));

    task automatic chk(input string tag, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(input int m, input logic [1:0] sel,
                                     input logic idc, input logic exc, input logic tk);
        if (sel == 2'd3) return "R1";
        if (sel == 2'd2) return "R5";
        if (sel == 2'd1) return (m == 2) ? "R7" : (m == 1) ? "R6" : "R3";
        if (exc && tk)   return "R8";
        if (exc)         return "R4";
        if (idc)         return (m == 2) ? "R7" : (m == 1) ? "R6" : "R8";
        return "R2";
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        // table walk
        for (int i = 0; i < NV; i++) begin
            logic [15:0] v;
            @(negedge clk);
            v         = VEC[i];
            rst_n     = v[15];
            id_cti    = v[14];
            ex_cti    = v[13];
            ex_taken  = v[12];
            pc_plus4  = 32'h0000_0100 + AW'(i * 4);
            ex_target = 32'hFFFF_F000 | AW'(i * 16);
            #4;
            for (int m = 0; m < 3; m++) begin
                logic [3:0] e;
                logic [AW-1:0] exp_pc;
                string t;
                e = v[11 - 4*m -: 4];
                t = tag_of(m, e[3:2], v[14], v[13], v[12]);
                chk(t, $sformatf("row %0d mode %0d {sel,fi,fe,pwe,iwe}", i, m),
                    AW'({sel_o[m], fi_o[m], fe_o[m], pwe_o[m], iwe_o[m]}),
                    AW'({e[3:2], e[1], e[0], (e[3:2] != 2'd2), ~e[1]}));
                if (e[3:2] != 2'd2) begin
                    exp_pc = (e[3:2] == 2'd1) ? ex_target :
                             (e[3:2] == 2'd3) ? '0 : pc_plus4;
                    chk(t, $sformatf("row %0d mode %0d pc_next", i, m), pcn_o[m], exp_pc);
                end
            end
        end

        // directed: reset wins over a live decode branch in the stall policy (R1)
        @(negedge clk);
        rst_n = 1'b0; id_cti = 1'b1; ex_cti = 1'b1; ex_taken = 1'b1;
        pc_plus4 = 32'h0000_0444;
        #4;
        chk("R1", "stall reset pc_sel", AW'(sel_o[0]), AW'(3));
        chk("R1", "stall reset pc_next", pcn_o[0], '0);
        chk("R1", "stall reset pc_we", AW'(pwe_o[0]), AW'(1));

        // directed: first cycle after release ignores both flags (R1)
        @(negedge clk);
        rst_n = 1'b1;
        #4;
        for (int m = 0; m < 3; m++)
            chk("R1", $sformatf("post-reset mode %0d pc_sel", m), AW'(sel_o[m]), AW'(0));

        // directed: speculative taken branch whose target equals pc_plus4 still squashes (R7)
        @(negedge clk);
        id_cti = 1'b0; ex_cti = 1'b0; ex_taken = 1'b0;
        @(negedge clk);
        ex_cti = 1'b1; ex_taken = 1'b1; ex_target = 32'h0000_0200; pc_plus4 = 32'h0000_0200;
        #4;
        chk("R7", "spec same-target idex_flush", AW'(fe_o[2]), AW'(1));
        chk("R7", "spec same-target ifid_flush", AW'(fi_o[2]), AW'(1));
        chk("R6", "dslot same-target idex_flush", AW'(fe_o[1]), AW'(0));

        @(negedge clk);
        ex_cti = 1'b0; ex_taken = 1'b0;
        done = 1'b1;
        summary();
        $finish;
    end

endmodule